// File: doc/BRIEF.md
# YUV Subsampling Output Format Multiplexer

The block takes three parallel 8-bit sample streams, luma on lane A and the two chroma components on lanes B and C, one sample of each per clock. It repacks them onto three output buses according to a 2-bit format select. The formats are full-rate pass-through (4:4:4), alternating chroma on one bus (4:2:2), and a quarter-rate chroma format (4:1:1). In 4:1:1 the two chroma words of every fourth sample are cut into 2-bit slices and sent over four clocks on the upper half of bus B. Marker flags on the two top bits of bus C tell a receiver where each chroma group begins and ends.

A rising edge on the initialization strobe sets the sample sequence position. The sample taken at that clock becomes sample 0, and its data appears on the buses a fixed number of clocks later. The output stays flagged invalid until the first such edge has travelled through the pipeline. Each output bus has its own drive-enable mask, one bit per data line. A clear bit means the line is not driven, and the data bit reads as 0. Each bus also has its own enable input that gates the whole bus at once.

Top module: `yuv_fmt_mux`

## Requirements
- R1: The format select `fmt` is encoded as 2'b00 = 4:1:1, 2'b01 = 4:4:4, 2'b10 = 4:2:2. The code 2'b11 leaves every bit of all three buses undriven (enable masks zero, data zero) while `out_valid` still follows the sequence.
- R2: A sample presented at rising edge k reaches the buses after rising edge k+LAT (LAT = 6 by default). `out_valid` goes high after edge r+LAT, where r is the first edge at which `init` is seen high after being low or after reset.
- R3: Before the first initialization edge has reached the output, `out_valid` is 0 and all enable masks are zero.
- R4: In 4:4:4 mode, bus A carries Y, bus B carries U and bus C carries V of every sample, all bits driven.
- R5: In 4:2:2 mode, bus A carries Y of every sample. Bus B carries U of an even-positioned sample, then V of that same sample at the next (odd) position. All bits of A and B are driven.
- R6: In 4:2:2 mode, bus C bits [7:6] are 2'b10 while U is on bus B and 2'b01 while V is on bus B. Bus C bits [5:0] are undriven.
- R7: In 4:1:1 mode, bus A carries Y of every sample. At group position k (0..3), bus B[7:6] = U[7-2k:6-2k] and B[5:4] = V[7-2k:6-2k], where U and V are taken from the position-0 sample of the group. Bus B[3:0] is undriven.
- R8: In 4:1:1 mode, bus C bits [7:6] give 2'b10, 2'b00, 2'b00, 2'b01 at positions 0, 1, 2, 3. Bus C bits [5:0] are undriven.
- R9: Enable inputs `oe_a`, `oe_b` and `oe_c` are active high and act in the same cycle. When one is low, the whole mask of that bus is zero and its data reads 0.
- R10: A later rising edge of `init` restarts the position count at 0 for the sample taken at that edge, even in the middle of a group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Sequence alignment strobe; its rising edge marks sample 0 |
| fmt | input | 2 | Output format select |
| oe_a | input | 1 | Drive enable for bus A |
| oe_b | input | 1 | Drive enable for bus B |
| oe_c | input | 1 | Drive enable for bus C |
| y_in | input | DW | Luma sample |
| u_in | input | DW | First chroma sample |
| v_in | input | DW | Second chroma sample |
| bus_a | output | DW | Output bus A data |
| bus_a_en | output | DW | Per-bit drive mask of bus A |
| bus_b | output | DW | Output bus B data |
| bus_b_en | output | DW | Per-bit drive mask of bus B |
| bus_c | output | DW | Output bus C data and marker flags |
| bus_c_en | output | DW | Per-bit drive mask of bus C |
| out_valid | output | 1 | Output sequence has been aligned |

## Verification
The bench builds the block with its defaults, DW = 8 and LAT = 6. At these values the 2-bit chroma slices, the flag field on bits [7:6] and the six-clock offset between a sample and its output all match the requirement text exactly. The six-clock depth is short enough that the first valid cycle, a mid-group realignment in 4:1:1, and a format switch with its settling window all fit within a few hundred cycles. The enables are toggled while the 4:2:2, 4:1:1 and 4:4:4 sequences run, so masking can be seen on top of every packing pattern.

// File: rtl/yfm_pkg.sv
package yfm_pkg;

   typedef enum logic [1:0] {
      FMT_411  = 2'b00,
      FMT_444  = 2'b01,
      FMT_422  = 2'b10,
      FMT_NONE = 2'b11
   } fmt_e;

   typedef logic [1:0] slot_t;

   localparam int          FLAG_W    = 2;
   localparam logic [1:0]  FLAG_HEAD = 2'b10;
   localparam logic [1:0]  FLAG_MID  = 2'b00;
   localparam logic [1:0]  FLAG_TAIL = 2'b01;

endpackage

// File: rtl/yfm_phase_track.sv
module yfm_phase_track
   import yfm_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  init,
   output slot_t slot,
   output logic  live
);
   logic  init_q;
   logic  run;
   slot_t cnt;
   logic  edge_hit;

   assign edge_hit = init & ~init_q;
   assign slot     = edge_hit ? slot_t'(0) : cnt;
   assign live     = run | edge_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q <= 1'b0;
         cnt    <= '0;
         run    <= 1'b0;
      end else begin
         init_q <= init;
         cnt    <= slot + slot_t'(1);
         run    <= live;
      end
   end

   // once aligned, the stream never falls back to the unaligned state
   assert_aligned_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> run);

endmodule

// File: rtl/yfm_delay.sv
module yfm_delay #(
   parameter int W   = 27,
   parameter int LAT = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (LAT < 1) begin : g_bad
         $error("yfm_delay: LAT must be at least 1");
      end
   endgenerate

   logic [W-1:0] stage [LAT];

   generate
      for (genvar i = 0; i < LAT; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[i] <= '0;
            else if (i == 0) stage[i] <= din;
            else stage[i] <= stage[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign dout = stage[LAT-1];

endmodule

// File: rtl/yfm_packer.sv
module yfm_packer
   import yfm_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    fmt,
   input  logic          st,
   input  slot_t         slot,
   input  logic [DW-1:0] y,
   input  logic [DW-1:0] u,
   input  logic [DW-1:0] v,
   output logic [DW-1:0] a_q,
   output logic [DW-1:0] b_q,
   output logic [DW-1:0] c_q,
   output logic [DW-1:0] a_en_q,
   output logic [DW-1:0] b_en_q,
   output logic [DW-1:0] c_en_q,
   output logic          vld_q
);
   localparam int SW = DW / 4;
   localparam int HW = DW / 2;
   localparam logic [DW-1:0] ALL_ON  = {DW{1'b1}};
   localparam logic [DW-1:0] FLAG_EN = {{FLAG_W{1'b1}}, {(DW-FLAG_W){1'b0}}};
   localparam logic [DW-1:0] HI_EN   = {{HW{1'b1}}, {HW{1'b0}}};

   generate
      if ((DW % 4) != 0 || DW < 4) begin : g_bad
         $error("yfm_packer: DW must be a multiple of 4");
      end
   endgenerate

   fmt_e mode;
   assign mode = fmt_e'(fmt);

   logic [DW-1:0] hold_u, hold_v;
   logic          hold_we;
   fmt_e          mq;

   assign hold_we = st && ((mode == FMT_411) ? (slot == 2'd0) : !slot[0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_u <= '0;
         hold_v <= '0;
      end else if (hold_we) begin
         hold_u <= u;
         hold_v <= v;
      end
   end

   logic [DW-1:0]     src_u, src_v, sh_u, sh_v;
   logic [DW-1:0]     a_n, b_n, c_n, ae_n, be_n, ce_n;
   logic [FLAG_W-1:0] flag;

   always_comb begin
      src_u = (slot == 2'd0) ? u : hold_u;
      src_v = (slot == 2'd0) ? v : hold_v;
      sh_u  = src_u << (int'(slot) * SW);
      sh_v  = src_v << (int'(slot) * SW);
      a_n  = '0; b_n  = '0; c_n  = '0;
      ae_n = '0; be_n = '0; ce_n = '0;
      flag = FLAG_MID;
      unique case (mode)
         FMT_444: begin
            a_n = y; b_n = u; c_n = v;
            ae_n = ALL_ON; be_n = ALL_ON; ce_n = ALL_ON;
         end
         FMT_422: begin
            a_n  = y;
            b_n  = slot[0] ? hold_v : u;
            flag = slot[0] ? FLAG_TAIL : FLAG_HEAD;
            c_n  = {flag, {(DW-FLAG_W){1'b0}}};
            ae_n = ALL_ON; be_n = ALL_ON; ce_n = FLAG_EN;
         end
         FMT_411: begin
            a_n = y;
            b_n = {sh_u[DW-1 -: SW], sh_v[DW-1 -: SW], {HW{1'b0}}};
            unique case (slot)
               2'd0:    flag = FLAG_HEAD;
               2'd3:    flag = FLAG_TAIL;
               default: flag = FLAG_MID;
            endcase
            c_n  = {flag, {(DW-FLAG_W){1'b0}}};
            ae_n = ALL_ON; be_n = HI_EN; ce_n = FLAG_EN;
         end
         default: ;
      endcase
      if (!st) begin
         a_n  = '0; b_n  = '0; c_n  = '0;
         ae_n = '0; be_n = '0; ce_n = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0; b_q <= '0; c_q <= '0;
         a_en_q <= '0; b_en_q <= '0; c_en_q <= '0;
         vld_q <= 1'b0;
         mq    <= FMT_444;
      end else begin
         a_q <= a_n; b_q <= b_n; c_q <= c_n;
         a_en_q <= ae_n; b_en_q <= be_n; c_en_q <= ce_n;
         vld_q <= st;
         mq    <= mode;
      end
   end

   assert_idle_undriven_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && mq == FMT_NONE) |-> ((a_en_q | b_en_q | c_en_q) == '0));

   assert_slice_low_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && mq == FMT_411) |-> (b_q[HW-1:0] == '0 && b_en_q[HW-1:0] == '0));

   assert_group_wraps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && mq == FMT_411 && c_q[DW-1 -: FLAG_W] == FLAG_TAIL) |=>
      (!vld_q || mq != FMT_411 || c_q[DW-1 -: FLAG_W] == FLAG_HEAD));

   assert_pair_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && mq == FMT_422) |->
      ($countones(c_q[DW-1 -: FLAG_W]) == 1 && c_en_q[DW-FLAG_W-1:0] == '0));

endmodule

// File: rtl/yuv_fmt_mux.sv
module yuv_fmt_mux
   import yfm_pkg::*;
#(
   parameter int DW  = 8,
   parameter int LAT = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init,
   input  logic [1:0]    fmt,
   input  logic          oe_a,
   input  logic          oe_b,
   input  logic          oe_c,
   input  logic [DW-1:0] y_in,
   input  logic [DW-1:0] u_in,
   input  logic [DW-1:0] v_in,
   output logic [DW-1:0] bus_a,
   output logic [DW-1:0] bus_a_en,
   output logic [DW-1:0] bus_b,
   output logic [DW-1:0] bus_b_en,
   output logic [DW-1:0] bus_c,
   output logic [DW-1:0] bus_c_en,
   output logic          out_valid
);
   localparam int NBUS = 3;
   localparam int PW   = 1 + $bits(slot_t) + 3*DW;

   slot_t slot_in, slot_d;
   logic  live_in, live_d;
   logic [DW-1:0] y_d, u_d, v_d;

   yfm_phase_track u_track (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (init),
      .slot  (slot_in),
      .live  (live_in)
   );

   yfm_delay #(.W(PW), .LAT(LAT)) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({live_in, slot_in, y_in, u_in, v_in}),
      .dout  ({live_d, slot_d, y_d, u_d, v_d})
   );

   logic [NBUS-1:0][DW-1:0] dq, eq, dgate, egate;
   logic [NBUS-1:0]         oe;

   assign oe = {oe_c, oe_b, oe_a};

   yfm_packer #(.DW(DW)) u_pack (
      .clk    (clk),
      .rst_n  (rst_n),
      .fmt    (fmt),
      .st     (live_d),
      .slot   (slot_d),
      .y      (y_d),
      .u      (u_d),
      .v      (v_d),
      .a_q    (dq[0]),
      .b_q    (dq[1]),
      .c_q    (dq[2]),
      .a_en_q (eq[0]),
      .b_en_q (eq[1]),
      .c_en_q (eq[2]),
      .vld_q  (out_valid)
   );

   generate
      for (genvar g = 0; g < NBUS; g++) begin : g_bus
         assign egate[g] = eq[g] & {DW{oe[g]}};
         assign dgate[g] = dq[g] & egate[g];
      end
   endgenerate

   assign bus_a    = dgate[0];
   assign bus_b    = dgate[1];
   assign bus_c    = dgate[2];
   assign bus_a_en = egate[0];
   assign bus_b_en = egate[1];
   assign bus_c_en = egate[2];

endmodule

// File: tb/yuv_fmt_mux_test.sv
`timescale 1ns/1ps
module yuv_fmt_mux_test;
   localparam int LAT = 6;
   localparam int N   = 1024;

   logic clk = 1'b0;
   logic rst_n, init, oe_a, oe_b, oe_c;
   logic [1:0] fmt;
   logic [7:0] y_in, u_in, v_in;
   logic [7:0] bus_a, bus_a_en, bus_b, bus_b_en, bus_c, bus_c_en;
   logic       out_valid;

   always #2.5 clk = ~clk;

   yuv_fmt_mux uut (
      .clk(clk), .rst_n(rst_n), .init(init), .fmt(fmt),
      .oe_a(oe_a), .oe_b(oe_b), .oe_c(oe_c),
      .y_in(y_in), .u_in(u_in), .v_in(v_in),
      .bus_a(bus_a), .bus_a_en(bus_a_en), .bus_b(bus_b), .bus_b_en(bus_b_en),
      .bus_c(bus_c), .bus_c_en(bus_c_en), .out_valid(out_valid)
   );

   int total = 0, bad = 0;
   bit done = 0;

   // history by edge index
   logic [7:0] y_h[N], u_h[N], v_h[N];
   logic [1:0] m_h[N], ph_h[N];
   logic       i_h[N], r_h[N], st_h[N];
   int  e = -1;
   logic ref_iq = 0, ref_run = 0;
   logic [1:0] ref_cnt = 0;
   int  rises = 0, last_rise = -100;

   task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h edge=%0d", req, what, act, exp, e);
      end
   endtask

   task automatic record_next();
      y_h[e+1] = y_in; u_h[e+1] = u_in; v_h[e+1] = v_in;
      m_h[e+1] = fmt;  i_h[e+1] = init; r_h[e+1] = rst_n;
   endtask

   task automatic check_edge();
      int s, k, base;
      logic [7:0] ea, eb, ec, ena, enb, enc;
      logic ev;
      logic [1:0] us, vs;
      string ta, tb, tc;
      bit stable;
      s = e - LAT;
      ev = (s >= 0) ? st_h[s] : 1'b0;
      ea = 0; eb = 0; ec = 0; ena = 0; enb = 0; enc = 0;
      ta = "R3"; tb = "R3"; tc = "R3";
      stable = (e >= 3) && m_h[e] == m_h[e-1] && m_h[e] == m_h[e-2] && m_h[e] == m_h[e-3];
      total++;
      if (out_valid !== ev) begin
         bad++;
         $display("FAIL %s out_valid actual=%b expected=%b edge=%0d", ev ? "R2" : "R3", out_valid, ev, e);
      end
      if (ev) begin
         k = ph_h[s];
         case (m_h[e])
            2'b01: begin
               ea = y_h[s]; eb = u_h[s]; ec = v_h[s]; ena = 8'hFF; enb = 8'hFF; enc = 8'hFF;
               ta = "R4"; tb = "R4"; tc = "R4";
            end
            2'b10: begin
               ea = y_h[s]; ena = 8'hFF; enb = 8'hFF; enc = 8'hC0;
               if (k % 2 == 0) begin eb = u_h[s]; ec = 8'h80; end
               else begin eb = v_h[s-1]; ec = 8'h40; end
               ta = "R5"; tb = "R5"; tc = "R6";
            end
            2'b00: begin
               base = s - k;
               us = 2'((u_h[base] >> (6 - 2*k)) & 8'h03);
               vs = 2'((v_h[base] >> (6 - 2*k)) & 8'h03);
               ea = y_h[s]; eb = {us, vs, 4'b0000};
               ena = 8'hFF; enb = 8'hF0; enc = 8'hC0;
               ec = (k == 0) ? 8'h80 : (k == 3) ? 8'h40 : 8'h00;
               ta = "R7"; tb = "R7"; tc = "R8";
            end
            default: begin ta = "R1"; tb = "R1"; tc = "R1"; end
         endcase
      end
      if (!oe_a) begin ea = 0; ena = 0; ta = "R9"; end
      if (!oe_b) begin eb = 0; enb = 0; tb = "R9"; end
      if (!oe_c) begin ec = 0; enc = 0; tc = "R9"; end
      if (!stable && ev) return;
      chk(ta, "bus_a", bus_a, ea);     chk(ta, "bus_a_en", bus_a_en, ena);
      chk(tb, "bus_b", bus_b, eb);     chk(tb, "bus_b_en", bus_b_en, enb);
      chk(tc, "bus_c", bus_c, ec);     chk(tc, "bus_c_en", bus_c_en, enc);
      // R10: realignment in the middle of a 4:1:1 group restarts at the head flag
      if (rises >= 2 && e == last_rise + LAT && m_h[e] == 2'b00 && oe_c)
         chk("R10", "bus_c_head_after_realign", bus_c, 8'h80);
   endtask

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         e++;
         if (r_h[e]) begin
            logic rise;
            rise = i_h[e] && !ref_iq;
            ph_h[e] = rise ? 2'd0 : ref_cnt;
            st_h[e] = ref_run | rise;
            if (rise) begin rises++; last_rise = e; end
            ref_iq = i_h[e]; ref_cnt = ph_h[e] + 2'd1; ref_run = st_h[e];
         end else begin
            ph_h[e] = 0; st_h[e] = 0; ref_iq = 0; ref_cnt = 0; ref_run = 0;
         end
         @(negedge clk);
         check_edge();
         y_in = 8'($urandom); u_in = 8'($urandom); v_in = 8'($urandom);
         record_next();
      end
   endtask

   task automatic set_ctl(logic [1:0] m, logic it, logic a, logic b, logic c);
      fmt = m; init = it; oe_a = a; oe_b = b; oe_c = c;
      record_next();
   endtask

   initial begin
      rst_n = 0; init = 0; fmt = 2'b01; oe_a = 1; oe_b = 1; oe_c = 1;
      y_in = 0; u_in = 0; v_in = 0;
      record_next();
      step(3);
      rst_n = 1; record_next();
      step(8);                          // R3: not yet aligned
      set_ctl(2'b01, 1, 1, 1, 1); step(30);   // R2, R4
      set_ctl(2'b10, 1, 1, 1, 1); step(30);   // R5, R6
      set_ctl(2'b10, 1, 1, 0, 1); step(8);    // R9
      set_ctl(2'b10, 1, 1, 1, 0); step(6);
      set_ctl(2'b00, 1, 1, 1, 1); step(30);   // R7, R8
      set_ctl(2'b00, 0, 1, 1, 1); step(2);
      set_ctl(2'b00, 1, 1, 1, 1); step(20);   // R10
      set_ctl(2'b00, 1, 0, 1, 1); step(6);
      set_ctl(2'b11, 1, 1, 1, 1); step(15);   // R1
      set_ctl(2'b01, 1, 1, 1, 0); step(20);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++; bad++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule